// File: doc/BRIEF.md
# Local Interrupt Controller Mode Register

This block keeps the 64-bit base-and-mode word of a local interrupt controller and decides, on every write, whether the requested change of operating mode is allowed. Two bits of the word select the mode: disabled, legacy memory-mapped access, or extended register-addressed access. A 24-bit field holds the page base used when the controller is reached through memory-mapped accesses.

A write is a 64-bit data word with a one-cycle strobe. Writes that ask for a permitted mode change, or keep the current mode, are stored. The stored copy keeps only the mode bits and the base field, and every other bit is cleared. A write that asks for a forbidden change leaves the register as it was and produces a one-cycle fault pulse. The read port always shows the stored word. The decoded mode and the base field are provided separately for neighbouring logic.

Top module: `lic_mode_reg`

## Requirements
- R1: After a synchronous active-low reset, the register holds bit 11 = 1 and bit 10 = 0 (legacy mode), with RESET_BASE in bits 35:12 and every other bit zero. fault_o is 0.
- R2: mode_o always equals {bit 11, bit 10} of the stored word. 2'b00 is disabled, 2'b10 is legacy and 2'b11 is extended. The combination 2'b01 never appears.
- R3: From disabled or legacy mode, a write whose bits 11:10 are 00, 10 or 11 is accepted. The masked value appears on rd_data in the cycle after the strobe.
- R4: In extended mode, a write with bit 11 = 1 and bit 10 = 0 is refused. The register is left unchanged.
- R5: In any mode, a write with bit 11 = 0 and bit 10 = 1 is refused. The register is left unchanged.
- R6: In extended mode, a write with both bits 11 and 10 clear is accepted and puts the block in the disabled mode.
- R7: A write that keeps the current mode is always accepted and updates the base field.
- R8: fault_o is high for exactly the one cycle after each refused write strobe. It stays low after accepted writes and on cycles without a strobe.
- R9: Bits outside 11, 10 and 35:12 are stored as zero and read back as zero, whatever was written.
- R10: page_base_o always equals bits 35:12 of the stored word.
- R11: On a cycle with wr_en low, the register keeps its value whatever is on wr_data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 64 | Write data word |
| rd_data | output | 64 | Stored register word |
| mode_o | output | 2 | Decoded mode: 00 disabled, 10 legacy, 11 extended |
| page_base_o | output | 24 | Page base field, bits 35:12 |
| fault_o | output | 1 | One-cycle pulse after a refused write |

## Verification
The bench tries to drop from extended mode straight to legacy mode. A design that handled this wrongly would store the value with no fault, so that the block slips back into memory-mapped access. It writes the invalid 01 combination from each of the three modes; a faulty design would either store it, leaving mode_o showing an undefined code, or raise no fault. Back-to-back refused writes, and refused writes followed by idle cycles, check that the fault is a pulse tied to each strobe and not a sticky level. Junk in the reserved bits, and illegal data on cycles with no strobe, expose a design that stores unmasked bits or acts on wr_data without a strobe.

// File: rtl/lic_mode_pkg.sv
// Package: shared mode type for the local interrupt controller mode register.
// Assumes the two mode bits are read as {global enable, extended enable}.
package lic_mode_pkg;

    typedef enum logic [1:0] {
        LM_OFF    = 2'b00,
        LM_BAD    = 2'b01,
        LM_LEGACY = 2'b10,
        LM_EXT    = 2'b11
    } lm_mode_e;

endpackage

// File: rtl/lic_mode_decode.sv
// Module: lic_mode_decode
// Extracts the operating mode from a data word by pulling out the enable
// and extended-enable bit positions. Pure combinational logic.
// Assumes ENA_POS and EXT_POS are distinct positions inside DATA_W.
module lic_mode_decode
    import lic_mode_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int ENA_POS = 11,
    parameter int EXT_POS = 10
) (
    input  logic [DATA_W-1:0] word_i,
    output lm_mode_e          mode_o
);

    // Pack the two control bits into the mode enumeration.
    always_comb begin
        mode_o = lm_mode_e'({word_i[ENA_POS], word_i[EXT_POS]});
    end

endmodule

// File: rtl/lic_mode_guard.sv
// Module: lic_mode_guard
// Decides whether a requested mode may follow the current one. It raises
// the accept signal for the same cycle, and registers a fault pulse for
// the cycle after a refused strobe.
// Assumes cur_mode_i never holds LM_BAD (the store only loads accepted words).
module lic_mode_guard
    import lic_mode_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  lm_mode_e cur_mode_i,
    input  lm_mode_e req_mode_i,
    output logic     accept_o,
    output logic     fault_o
);

    logic legal;
    logic fault_q;

    // Legality table for a requested mode given the current mode.
    always_comb begin
        legal = 1'b1;
        unique case (req_mode_i)
            LM_BAD:    legal = 1'b0;
            LM_LEGACY: legal = (cur_mode_i != LM_EXT);
            LM_OFF:    legal = 1'b1;
            LM_EXT:    legal = 1'b1;
            default:   legal = 1'b0;
        endcase
    end

    // Accept only when a strobe carries a legal request.
    always_comb begin
        accept_o = wr_en && legal;
    end

    // Register the fault so it pulses for the cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else begin
            fault_q <= wr_en && !legal;
        end
    end

    assign fault_o = fault_q;

    AST_NO_EXT_TO_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cur_mode_i == LM_EXT && req_mode_i == LM_LEGACY) |-> !accept_o); // R4
    AST_BAD_NEVER_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_mode_i == LM_BAD) |-> !accept_o); // R5

endmodule

// File: rtl/lic_mode_store.sv
// Module: lic_mode_store
// Holds the register word. Only the mode bits and the base field are kept;
// every other bit is forced to zero on load. Resets to legacy mode with
// a parameterised page base.
// Assumes the base field does not overlap the mode bit positions.
module lic_mode_store #(
    parameter int DATA_W   = 64,
    parameter int ENA_POS  = 11,
    parameter int EXT_POS  = 10,
    parameter int BASE_LSB = 12,
    parameter int BASE_MSB = 35,
    parameter logic [BASE_MSB-BASE_LSB:0] RESET_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] word_o
);

    localparam int BASE_W = BASE_MSB - BASE_LSB + 1;

    // Build the reset word: legacy enable plus default base.
    function automatic logic [DATA_W-1:0] reset_word();
        logic [DATA_W-1:0] w;
        w = '0;
        w[ENA_POS] = 1'b1;
        w[BASE_MSB:BASE_LSB] = RESET_BASE[BASE_W-1:0];
        return w;
    endfunction

    localparam logic [DATA_W-1:0] RST_WORD = reset_word();

    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] word_q;

    // One mask bit per position: kept if a mode bit or inside the base field.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        localparam bit KEEP = (i == ENA_POS) || (i == EXT_POS) ||
                              ((i >= BASE_LSB) && (i <= BASE_MSB));
        assign keep_mask[i] = KEEP;
    end

    // Storage: reset to the default word, load masked data when accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= RST_WORD;
        end else if (load_i) begin
            word_q <= data_i & keep_mask;
        end
    end

    assign word_o = word_q;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (word_q & ~keep_mask) == '0); // R9
    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(word_q)); // R11

endmodule

// File: rtl/lic_mode_reg.sv
// Module: lic_mode_reg (top)
// Base-and-mode register of a local interrupt controller. Checks each write
// against the current mode, stores accepted writes (masked) and pulses a
// fault for refused ones. It outputs the decoded mode and the page base.
// Assumes one write strobe per cycle at most; the read port is combinational.
module lic_mode_reg
    import lic_mode_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int ENA_POS  = 11,
    parameter int EXT_POS  = 10,
    parameter int BASE_LSB = 12,
    parameter int BASE_MSB = 35,
    parameter logic [BASE_MSB-BASE_LSB:0] RESET_BASE = 24'h0C0DE0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [DATA_W-1:0]          rd_data,
    output logic [1:0]                 mode_o,
    output logic [BASE_MSB-BASE_LSB:0] page_base_o,
    output logic                       fault_o
);

    localparam int BASE_W = BASE_MSB - BASE_LSB + 1;

    lm_mode_e          cur_mode;
    lm_mode_e          req_mode;
    logic              accept;
    logic [DATA_W-1:0] word;

    lic_mode_decode #(
        .DATA_W (DATA_W),
        .ENA_POS(ENA_POS),
        .EXT_POS(EXT_POS)
    ) u_dec_cur (
        .word_i(word),
        .mode_o(cur_mode)
    );

    lic_mode_decode #(
        .DATA_W (DATA_W),
        .ENA_POS(ENA_POS),
        .EXT_POS(EXT_POS)
    ) u_dec_req (
        .word_i(wr_data),
        .mode_o(req_mode)
    );

    lic_mode_guard u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .cur_mode_i(cur_mode),
        .req_mode_i(req_mode),
        .accept_o  (accept),
        .fault_o   (fault_o)
    );

    lic_mode_store #(
        .DATA_W    (DATA_W),
        .ENA_POS   (ENA_POS),
        .EXT_POS   (EXT_POS),
        .BASE_LSB  (BASE_LSB),
        .BASE_MSB  (BASE_MSB),
        .RESET_BASE(RESET_BASE)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(accept),
        .data_i(wr_data),
        .word_o(word)
    );

    // Drive the outputs from the stored word.
    always_comb begin
        rd_data     = word;
        mode_o      = cur_mode;
        page_base_o = word[BASE_MSB:BASE_LSB];
    end

    AST_MODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b01); // R2
    AST_EXT_LEGACY_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_o == 2'b11 && wr_data[ENA_POS] && !wr_data[EXT_POS])
        |=> (fault_o && $stable(rd_data))); // R4
    AST_BAD_COMBO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[ENA_POS] && wr_data[EXT_POS])
        |=> (fault_o && $stable(rd_data))); // R5
    AST_EXT_EXIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_o == 2'b11 && !wr_data[ENA_POS] && !wr_data[EXT_POS])
        |=> (mode_o == 2'b00 && !fault_o)); // R6
    AST_SAME_MODE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && {wr_data[ENA_POS], wr_data[EXT_POS]} == mode_o)
        |=> (page_base_o == $past(wr_data[BASE_MSB:BASE_LSB]))); // R7
    AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> $past(wr_en)); // R8
    AST_BASE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        page_base_o == rd_data[BASE_MSB:BASE_LSB]); // R10

    initial begin
        AST_BASE_WIDTH: assert (BASE_W > 0); // R10
    end

endmodule

// File: tb/lic_mode_reg_bench.sv
`timescale 1ns/1ps
module lic_mode_reg_bench;

    localparam logic [23:0] RST_BASE = 24'h0C0DE0;
    localparam logic [63:0] KEEP = 64'h0000_000F_FFFF_FC00;

    typedef struct {
        logic [63:0] rd;
        logic        fault;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic [1:0]  mode_o;
    logic [23:0] page_base_o;
    logic        fault_o;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    exp_t sb[$];
    logic [63:0] model;

    always #2.5 clk = ~clk;

    lic_mode_reg #(.RESET_BASE(RST_BASE)) u_lic_mode_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .mode_o     (mode_o),
        .page_base_o(page_base_o),
        .fault_o    (fault_o)
    );

    task automatic check64(string tag, string what, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Compare all outputs against one expected register word and fault.
    task automatic check_all(string tag, logic [63:0] rd, logic flt);
        check64(tag, "rd_data", rd_data, rd);
        check64(tag, "mode_o (R2)", {62'd0, mode_o}, {62'd0, rd[11], rd[10]});
        check64(tag, "page_base_o (R10)", {40'd0, page_base_o}, {40'd0, rd[35:12]});
        check64(tag, "fault_o", {63'd0, fault_o}, {63'd0, flt});
    endtask

    // Driver: one cycle with a strobe, model update, expected item pushed.
    task automatic wr(logic [63:0] d, string tag);
        logic [1:0] cur;
        logic [1:0] nw;
        logic       bad;
        exp_t       e;
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        cur = {model[11], model[10]};
        nw  = {d[11], d[10]};
        bad = (nw == 2'b01) || (cur == 2'b11 && nw == 2'b10);
        if (!bad) model = d & KEEP;
        e.rd = model; e.fault = bad; e.tag = tag;
        sb.push_back(e);
    endtask

    // Driver: one cycle without a strobe, arbitrary data on the bus.
    task automatic idle(logic [63:0] d, string tag);
        exp_t e;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = d;
        e.rd = model; e.fault = 1'b0; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: after each edge, pop the matching expected item and compare.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check_all(e.tag, e.rd, e.fault);
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        model = {28'd0, RST_BASE, 12'h800};
        check_all("R1 reset", model, 1'b0);

        wr(64'hFFFF_FFF1_2345_6BFF, "R7 R9 legacy rewrite, junk bits");
        idle(64'h0000_0000_0000_0400, "R11 idle with bad combo on bus");
        idle(64'hFFFF_FFFF_FFFF_FFFF, "R11 idle all ones");
        wr(64'h0000_000A_BCDE_FC00, "R3 legacy to extended");
        wr(64'h0000_0001_1111_1800, "R4 extended to legacy refused");
        idle(64'h0, "R8 fault drops");
        wr(64'h8000_0005_5555_5C00, "R7 extended rewrite base");
        wr(64'h0000_0002_2222_2400, "R5 bad combo from extended");
        wr(64'h0000_0003_3333_3800, "R4 back-to-back refused");
        idle(64'h0, "R8 fault single pulse");
        wr(64'h0000_0006_6666_6000, "R6 extended to disabled");
        wr(64'h0000_0007_7777_7400, "R5 bad combo from disabled");
        wr(64'h0000_0008_8888_8C00, "R3 disabled to extended");
        wr(64'h0000_0000_0000_0000, "R6 exit to disabled");
        wr(64'h0000_0009_9999_9800, "R3 disabled to legacy");
        wr(64'h0000_000B_BBBB_B400, "R5 bad combo from legacy");
        wr(64'h0000_0000_0000_0000, "R3 legacy to disabled");
        wr(64'h0000_000C_CCCC_C000, "R7 disabled rewrite base");
        idle(64'h0, "R11 final hold");
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule